// File: doc/BRIEF.md
# Dual-Table Baud Rate Generator

This block turns one fixed reference clock into two streams of single-cycle sample enables, one for a receiver and one for a transmitter. Each enable repeats at sixteen times the selected baud rate. The rate for each direction comes from a 4-bit code. Both codes arrive packed in one rate-select byte: the receiver code is in the upper nibble and the transmitter code is in the lower nibble. A global table-set bit picks between two standard rate tables, and a 2-bit extended-mode field reaches further rate sets. The same code can therefore mean different rates.

The divisor for every combination of mode, set and code is computed when the design is built, using the reference frequency parameter. At run time each direction only looks up a value and counts down. When a direction's selection changes, it reloads its counter from the table, so the new rate takes effect at once. A combination with no table entry keeps that direction's enable low.

Top module: `baud_gen_top`

## Requirements
- R1: While rstN is low, rxTick and txTick are both low.
- R2: Each enable is high for one cycle at a time and repeats every D cycles, where D = round(REF_HZ / (16 x baud)). With the default REF_HZ of 3686400 a rate of 230400 gives D = 1, which means the enable is high on every cycle.
- R3: With extMode = 0 and tableSet = 0, the codes map as follows: 0 gives 50 baud (D 4608), 4 gives 300 (768), 6 gives 1200 (192), 8 gives 2400 (96), 9 gives 4800 (48), 11 gives 9600 (24) and 12 gives 38400 (6).
- R4: rateSel bits 7:4 set the receiver rate and bits 3:0 set the transmitter rate, independently of each other.
- R5: tableSet = 1 selects the second table for both directions together: code 12 gives 19200 (D 12) and code 0 gives 75 (D 3072).
- R6: extMode = 1 selects the first extended set. With tableSet = 0, code 11 gives 57600 (D 4) and code 12 gives 230400 (D 1). With tableSet = 1, code 12 gives 115200 (D 2).
- R7: extMode = 2 selects the second extended set: code 1 gives 880 baud (D 262) and code 2 gives 1076 baud (D 214).
- R8: A combination with no table entry holds that direction's enable low. This covers codes 13 to 15 in every mode, all codes with extMode = 3, and extended-mode codes that are not listed (for example code 11 with extMode = 2).
- R9: When a direction's code, tableSet or extMode changes, that direction restarts. The new selection is presented before a rising edge. Counting that edge as the first, the first new pulse appears on rising edge D+2, and there is no pulse during the reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rateSel | input | 8 | Receiver code [7:4], transmitter code [3:0] |
| tableSet | input | 1 | Picks the rate table; shared by both directions |
| extMode | input | 2 | 0 normal, 1 extended set one, 2 extended set two, 3 none |
| rxTick | output | 1 | Receiver 16x sample enable |
| txTick | output | 1 | Transmitter 16x sample enable |

## Verification
The case that is hardest to reach from the ports is the restart timing after a selection change. A pulse left over from the old rate can fall on the very edge where the change is sampled, and that pulse would hide the restart. To avoid this, the stimulus first parks the receiver on a code with no table entry, so the receiver is silent. Only then does it present a valid code, and it counts rising edges until the first pulse appears. The slowest divisors also need long settle windows, so that each measured gap lies wholly after the reload.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  localparam int DIV_W   = 16;
  localparam int CODE_W  = 4;
  localparam int EXT_W   = 2;
  localparam int SEL_W   = EXT_W + 1 + CODE_W;
  localparam int TABLE_N = 1 << SEL_W;
  localparam int DIR_N   = 2;

  typedef struct packed {
    logic             reload;
    logic             valid;
    logic [DIV_W-1:0] divisor;
  } baud_strobe_t;

  // Rate in half-baud units (so 134.5 is exact); 0 marks no entry.
  function automatic int unsigned halfBaud(input logic [SEL_W-1:0] sel);
    logic [EXT_W-1:0]  ext;
    logic              set;
    logic [CODE_W-1:0] code;
    int unsigned       r;
    ext  = sel[SEL_W-1 -: EXT_W];
    set  = sel[CODE_W];
    code = sel[CODE_W-1:0];
    r = 0;
    case (ext)
      2'd0: begin
        if (!set) begin
          case (code)
            4'd0: r = 100;    4'd1: r = 220;    4'd2: r = 269;
            4'd3: r = 400;    4'd4: r = 600;    4'd5: r = 1200;
            4'd6: r = 2400;   4'd7: r = 2100;   4'd8: r = 4800;
            4'd9: r = 9600;   4'd10: r = 14400; 4'd11: r = 19200;
            4'd12: r = 76800;
            default: r = 0;
          endcase
        end else begin
          case (code)
            4'd0: r = 150;    4'd1: r = 220;    4'd2: r = 269;
            4'd3: r = 300;    4'd4: r = 600;    4'd5: r = 1200;
            4'd6: r = 2400;   4'd7: r = 4000;   4'd8: r = 4800;
            4'd9: r = 9600;   4'd10: r = 3600;  4'd11: r = 19200;
            4'd12: r = 38400;
            default: r = 0;
          endcase
        end
      end
      2'd1: begin
        if (!set) begin
          case (code)
            4'd8: r = 28800;  4'd9: r = 57600;
            4'd11: r = 115200; 4'd12: r = 460800;
            default: r = 0;
          endcase
        end else begin
          case (code)
            4'd0: r = 900;    4'd3: r = 1800;
            4'd5: r = 7200;   4'd12: r = 230400;
            default: r = 0;
          endcase
        end
      end
      2'd2: begin
        case (code)
          4'd1: r = 1760;
          4'd2: r = 2152;
          default: r = 0;
        endcase
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  // round(ref / (16 * baud)) with baud given in half units.
  function automatic logic [DIV_W-1:0] divisorOf(input longint unsigned refHz,
                                                 input int unsigned halfRate);
    longint unsigned num;
    longint unsigned den;
    if (halfRate == 0) return '0;
    num = 2 * refHz + 8 * longint'(halfRate);
    den = 16 * longint'(halfRate);
    return DIV_W'(num / den);
  endfunction

endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter longint unsigned REF_HZ = 3686400
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [DIR_N*CODE_W-1:0]  rateSel,
  input  logic                     tableSet,
  input  logic [EXT_W-1:0]         extMode,
  output baud_strobe_t [DIR_N-1:0] strobes
);

  logic [DIV_W-1:0] divRom [TABLE_N];

  for (genvar i = 0; i < TABLE_N; i++) begin : g_rom
    assign divRom[i] = divisorOf(REF_HZ, halfBaud(SEL_W'(i)));
  end

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    logic [CODE_W-1:0] code;
    logic [SEL_W-1:0]  sel;
    logic [SEL_W-1:0]  prevSel;
    logic              primed;
    logic              change;
    baud_strobe_t      strobeReg;

    // direction 0 (receiver) takes the upper nibble
    assign code   = rateSel[(DIR_N-d)*CODE_W-1 -: CODE_W];
    assign sel    = {extMode, tableSet, code};
    assign change = !primed || (sel != prevSel);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevSel   <= '0;
        primed    <= 1'b0;
        strobeReg <= '0;
      end else begin
        primed           <= 1'b1;
        prevSel          <= sel;
        strobeReg.reload <= change;
        if (change) begin
          strobeReg.divisor <= divRom[sel];
          strobeReg.valid   <= (divRom[sel] != '0);
        end
      end
    end

    assign strobes[d] = strobeReg;
  end

endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_gen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  baud_strobe_t strobe,
  output logic         tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] divReg;
  logic             active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divReg <= '0;
      active <= 1'b0;
      tick   <= 1'b0;
    end else if (strobe.reload) begin
      divReg <= strobe.divisor;
      cnt    <= strobe.divisor - DIV_W'(1);
      active <= strobe.valid;
      tick   <= 1'b0;
    end else if (active) begin
      if (cnt == '0) begin
        cnt  <= divReg - DIV_W'(1);
        tick <= 1'b1;
      end else begin
        cnt  <= cnt - DIV_W'(1);
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_gen_top.sv
module baud_gen_top
  import baud_gen_pkg::*;
#(
  parameter longint unsigned REF_HZ = 3686400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] rateSel,
  input  logic       tableSet,
  input  logic [1:0] extMode,
  output logic       rxTick,
  output logic       txTick
);

  baud_strobe_t [DIR_N-1:0] strobes;
  logic [DIR_N-1:0]         tickVec;

  baud_gen_ctrl #(.REF_HZ(REF_HZ)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rateSel  (rateSel),
    .tableSet (tableSet),
    .extMode  (extMode),
    .strobes  (strobes)
  );

  for (genvar d = 0; d < DIR_N; d++) begin : g_div
    baud_divider u_div (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobes[d]),
      .tick   (tickVec[d])
    );
  end

  assign rxTick = tickVec[0];
  assign txTick = tickVec[1];

endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk
  import baud_gen_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input logic [DIR_N-1:0]         ticks,
  input baud_strobe_t [DIR_N-1:0] strobes
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |-> (ticks == '0));

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    // R2: a pulse lasts one cycle unless the divisor is one
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
      (ticks[d] && !strobes[d].reload && strobes[d].divisor > DIV_W'(1)) |=> !ticks[d]);

    // R8: no table entry keeps the enable low
    p_invalid_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[d].valid |=> !ticks[d]);

    // R9: the reload cycle carries no pulse
    p_reload_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
      strobes[d].reload |=> !ticks[d]);
  end

endmodule

bind baud_gen_top baud_gen_chk i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ticks   (tickVec),
  .strobes (strobes)
);

// File: tb/test_baud_gen_top.sv
module test_baud_gen_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] rateSel = 8'h00;
  logic       tableSet = 1'b0;
  logic [1:0] extMode = 2'd0;
  logic       rxTick;
  logic       txTick;

  always #5 clk = ~clk;

  baud_gen_top i_baud_gen_top (
    .clk      (clk),
    .rstN     (rstN),
    .rateSel  (rateSel),
    .tableSet (tableSet),
    .extMode  (extMode),
    .rxTick   (rxTick),
    .txTick   (txTick)
  );

  typedef struct {
    int    expGap;
    string tag;
  } exp_t;

  exp_t   rxQ[$];
  exp_t   txQ[$];
  int     checks = 0;
  int     bad = 0;
  longint cyc = 0;
  longint rxLast = 0;
  longint txLast = 0;
  bit     rxHave = 0;
  bit     txHave = 0;
  int     rxCount = 0;
  int     txCount = 0;

  task automatic report(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures gaps between pulses and compares against the scoreboard
  always @(negedge clk) begin
    exp_t it;
    cyc++;
    if (rxTick) begin
      if (rxHave && rxQ.size() > 0) begin
        it = rxQ.pop_front();
        report({it.tag, " rx gap"}, cyc - rxLast, it.expGap);
      end
      rxLast = cyc;
      rxHave = 1;
      rxCount++;
    end
    if (txTick) begin
      if (txHave && txQ.size() > 0) begin
        it = txQ.pop_front();
        report({it.tag, " tx gap"}, cyc - txLast, it.expGap);
      end
      txLast = cyc;
      txHave = 1;
      txCount++;
    end
  end

  task automatic applySel(input logic [7:0] b, input logic s, input logic [1:0] e);
    @(negedge clk);
    rateSel  = b;
    tableSet = s;
    extMode  = e;
  endtask

  // driver: expected gap 0 means the direction must stay silent
  task automatic expectRates(input logic [7:0] b, input logic s, input logic [1:0] e,
                             input int rxD, input int txD, input string tag);
    int w;
    int rc;
    int tc;
    applySel(b, s, e);
    w = 2 * ((rxD > txD) ? rxD : txD) + 8;
    repeat (w) @(negedge clk);
    rc = rxCount;
    tc = txCount;
    if (rxD > 0) rxQ.push_back('{rxD, tag});
    if (txD > 0) txQ.push_back('{txD, tag});
    while (rxQ.size() > 0 || txQ.size() > 0) @(negedge clk);
    if (rxD == 0 || txD == 0) begin
      repeat (300) @(negedge clk);
      if (rxD == 0) report({tag, " rx silent"}, rxCount - rc, 0);
      if (txD == 0) report({tag, " tx silent"}, txCount - tc, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int k;
    // R1: quiet during reset
    repeat (3) begin
      @(negedge clk);
      report("R1 reset rx", rxTick, 0);
      report("R1 reset tx", txTick, 0);
    end
    @(negedge clk);
    rstN = 1'b1;

    // R2 R3: normal table, set 0
    expectRates(8'hBB, 1'b0, 2'd0, 24, 24, "R3 9600");
    // R4: nibbles split between directions
    expectRates(8'hC6, 1'b0, 2'd0, 6, 192, "R4 38400/1200");
    expectRates(8'h48, 1'b0, 2'd0, 768, 96, "R3 300/2400");
    expectRates(8'h98, 1'b0, 2'd0, 48, 96, "R3 4800/2400");
    expectRates(8'h0C, 1'b0, 2'd0, 4608, 6, "R3 50/38400");
    // R5: second table, shared by both directions
    expectRates(8'hC0, 1'b1, 2'd0, 12, 3072, "R5 19200/75");
    // R6: first extended set
    expectRates(8'hBC, 1'b0, 2'd1, 4, 1, "R6 57600/230400");
    expectRates(8'hCC, 1'b1, 2'd1, 2, 2, "R6 115200");
    // R7: second extended set
    expectRates(8'h12, 1'b0, 2'd2, 262, 214, "R7 880/1076");
    // R8: combinations without an entry
    expectRates(8'hDC, 1'b0, 2'd0, 0, 6, "R8 code13");
    expectRates(8'hB1, 1'b0, 2'd2, 0, 262, "R8 ext2 code11");
    expectRates(8'hBB, 1'b0, 2'd3, 0, 0, "R8 ext3");
    expectRates(8'hDD, 1'b0, 2'd0, 0, 0, "R8 code13 both");

    // R9: restart latency from a silent receiver, D = 6
    applySel(8'hCD, 1'b0, 2'd0);
    k = 0;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (rxTick) break;
    end
    report("R9 first pulse edge", k, 8);
    expectRates(8'hCD, 1'b0, 2'd0, 6, 0, "R9 after restart");

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule